// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold Interrupts

This block sits between a host-side register port and a serial bus engine. It holds two byte queues. The transmit queue is written by the host and drained by the engine. The receive queue is filled by the engine and drained by the host. Each queue has an enable and a programmable trigger level.

The block turns queue state into interrupt causes:
- a low-water cause for transmit and a high-water cause for receive;
- sticky overrun and underrun errors on both queues;
- a trailing-data cause that reports receive bytes left below the trigger level while the bus stays idle;
- a pass-through transfer-event cause from the engine.

All causes collect in one status word with write-one-to-clear semantics. The status word is masked by an enable word into a single registered interrupt line. A packed fill-status word gives both levels with their full and empty flags. Register decode and the serial engine live outside this block.

Top module: `dual_fifo_irq`

## Requirements
- R1: Each queue stores up to DEPTH (default 64) bytes in first-in first-out order. A read strobe on a non-empty queue presents the oldest byte on the read-data output after that clock edge, and the output holds until the next read.
- R2: `fifo_stat_o` reports the transmit level in bits 6:0, transmit full in bit 7 and transmit empty in bit 8. It reports the receive level in bits 22:16, receive full in bit 23 and receive empty in bit 24. All other bits are zero. After reset the word reads 0x01000100.
- R3: Status bit 0 (transmit low-water) is set on every clock edge where the transmit queue is enabled and its level is at or below `tx_trig_i`.
- R4: Status bit 1 (receive high-water) is set on every clock edge where the receive queue is enabled and its level is at or above `rx_trig_i`.
- R5: Error flags are sticky:
  - A host write to a full transmit queue sets bit 3 and drops the byte.
  - An engine read of an empty transmit queue sets bit 2 and returns zero.
  - An engine write to a full receive queue sets bit 5 and drops the byte.
  - A host read of an empty receive queue sets bit 4 and returns zero.
- R6: A pulse on `int_clr_i` clears exactly the status bits set in `int_clr_mask_i`. A cause arriving in the same cycle wins over the clear. Bit 9 is set by a pulse on `xfer_evt_i`. Bits 7 and 8 always read zero. Every status bit updates on the clock edge that samples its cause.
- R7: `irq_o` is a register loaded each edge with the OR of the next status word ANDed with `int_en_i`. An all-zero enable word holds it low.
- R8: Status bit 6 (trailing) is set on the idle tick that completes `trail_lim_i` consecutive idle ticks. During every one of those ticks the receive queue must be enabled and hold between one byte and one below its trigger level. A receive push, a receive pop, an empty queue or a level at the trigger restarts the count. The count fires once per run. A limit of zero disables it.
- R9: A pulse on `soft_rst_i` empties both queues, zeroes both read-data outputs and the trailing count, clears the status word and drops `irq_o`.
- R10: A disabled queue is held empty with zero read data. Reads and writes to it are ignored and raise no error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | Soft reset pulse: flush queues, clear status |
| tx_en_i | input | 1 | Transmit queue enable |
| rx_en_i | input | 1 | Receive queue enable |
| tx_trig_i | input | 7 | Transmit low-water trigger level |
| rx_trig_i | input | 7 | Receive high-water trigger level |
| int_en_i | input | 10 | Interrupt enable mask, same bit positions as status |
| trail_lim_i | input | 4 | Number of idle ticks before the trailing cause |
| host_tx_wr_i | input | 1 | Host write strobe into the transmit queue |
| host_tx_data_i | input | 8 | Host write byte |
| host_rx_rd_i | input | 1 | Host read strobe from the receive queue |
| host_rx_data_o | output | 8 | Registered byte read by the host |
| eng_tx_rd_i | input | 1 | Engine read strobe from the transmit queue |
| eng_tx_data_o | output | 8 | Registered byte read by the engine |
| eng_rx_wr_i | input | 1 | Engine write strobe into the receive queue |
| eng_rx_data_i | input | 8 | Engine write byte |
| idle_tick_i | input | 1 | One pulse per idle bus period, from the engine |
| xfer_evt_i | input | 1 | Transfer event pulse from the engine |
| int_clr_i | input | 1 | Status clear strobe |
| int_clr_mask_i | input | 10 | Bits to clear, one per status bit |
| fifo_stat_o | output | 32 | Packed levels and full/empty flags |
| int_stat_o | output | 10 | Sticky interrupt status |
| irq_o | output | 1 | Masked interrupt output |

## Verification
The bench fills the transmit queue to exactly 64 and writes once more. A design whose full flag was off by one would either accept a 65th byte or report the overrun one byte early. It drains both queues past empty. A design that returned stale data instead of zero, or forgot the sticky underrun bit, would show it at the read-data output. It clears status by writing back the word it just read while causes keep firing, which catches a clear that wins over a new cause. It also lets receive data sit below the trigger through many idle ticks, which exposes a trailing counter that fires early, late, or repeatedly. Random phases toggle enables and soft reset mid-traffic. A queue that kept stale bytes across a flush would then emit them out of order.

// File: rtl/dfi_pkg.sv
package dfi_pkg;
  localparam int NSTAT = 10;
  // status bit positions (decoded by software, so fixed)
  localparam int S_TXAE  = 0;
  localparam int S_RXAF  = 1;
  localparam int S_TXUDF = 2;
  localparam int S_TXOVF = 3;
  localparam int S_RXUDF = 4;
  localparam int S_RXOVF = 5;
  localparam int S_TRAIL = 6;
  localparam int S_XFER  = 9;
  // fill-status word positions
  localparam int F_TXLVL   = 0;
  localparam int F_TXFULL  = 7;
  localparam int F_TXEMPTY = 8;
  localparam int F_RXLVL   = 16;
  localparam int F_RXFULL  = 23;
  localparam int F_RXEMPTY = 24;
endpackage

// File: rtl/dfi_byte_fifo.sv
module dfi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          udf
);
  logic [DW-1:0] mem [DEPTH];
  logic [LW-1:0] wp, rp;
  logic          push, pop;

  assign level = wp - rp;
  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign ovf   = wr & full;
  assign udf   = rd & empty;
  assign push  = wr & ~full;
  assign pop   = rd & ~empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      rdata <= '0;
    end else begin
      if (push) wp <= wp + LW'(1);
      if (rd)   rdata <= empty ? '0 : mem[rp[AW-1:0]];
      if (pop)  rp <= rp + LW'(1);
    end
  end
endmodule

// File: rtl/dfi_trail_timer.sv
module dfi_trail_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] lim,
  output logic          fire
);
  logic [CW-1:0] cnt;

  assign fire = tick & ~clr & (lim != '0) & (cnt == lim - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)             cnt <= '0;
    else if (tick && cnt < lim) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
  import dfi_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DW      = 8,
  parameter int TRAIL_W = 4,
  localparam int LW     = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst_i,
  input  logic               tx_en_i,
  input  logic               rx_en_i,
  input  logic [LW-1:0]      tx_trig_i,
  input  logic [LW-1:0]      rx_trig_i,
  input  logic [NSTAT-1:0]   int_en_i,
  input  logic [TRAIL_W-1:0] trail_lim_i,
  input  logic               host_tx_wr_i,
  input  logic [DW-1:0]      host_tx_data_i,
  input  logic               host_rx_rd_i,
  output logic [DW-1:0]      host_rx_data_o,
  input  logic               eng_tx_rd_i,
  output logic [DW-1:0]      eng_tx_data_o,
  input  logic               eng_rx_wr_i,
  input  logic [DW-1:0]      eng_rx_data_i,
  input  logic               idle_tick_i,
  input  logic               xfer_evt_i,
  input  logic               int_clr_i,
  input  logic [NSTAT-1:0]   int_clr_mask_i,
  output logic [31:0]        fifo_stat_o,
  output logic [NSTAT-1:0]   int_stat_o,
  output logic               irq_o
);
  logic [LW-1:0]    tx_lvl, rx_lvl;
  logic             tx_full, tx_empty, tx_ovf, tx_udf;
  logic             rx_full, rx_empty, rx_ovf, rx_udf;
  logic             rx_qual, rx_act, trail_clr, trail_fire;
  logic [NSTAT-1:0] cause, clr_bits, stat_nxt;

  dfi_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst(rst), .flush(soft_rst_i | ~tx_en_i),
    .wr(host_tx_wr_i & tx_en_i), .wdata(host_tx_data_i),
    .rd(eng_tx_rd_i & tx_en_i), .rdata(eng_tx_data_o),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty),
    .ovf(tx_ovf), .udf(tx_udf)
  );

  dfi_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst(rst), .flush(soft_rst_i | ~rx_en_i),
    .wr(eng_rx_wr_i & rx_en_i), .wdata(eng_rx_data_i),
    .rd(host_rx_rd_i & rx_en_i), .rdata(host_rx_data_o),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty),
    .ovf(rx_ovf), .udf(rx_udf)
  );

  // trailing: data present but under the trigger, and no traffic
  assign rx_qual   = rx_en_i & ~rx_empty & (rx_lvl < rx_trig_i);
  assign rx_act    = rx_en_i & (eng_rx_wr_i | host_rx_rd_i);
  assign trail_clr = soft_rst_i | ~rx_qual | rx_act;

  dfi_trail_timer #(.CW(TRAIL_W)) u_trail (
    .clk(clk), .rst(rst), .clr(trail_clr), .tick(idle_tick_i),
    .lim(trail_lim_i), .fire(trail_fire)
  );

  always_comb begin
    cause          = '0;
    cause[S_TXAE]  = tx_en_i & (tx_lvl <= tx_trig_i);
    cause[S_RXAF]  = rx_en_i & (rx_lvl >= rx_trig_i);
    cause[S_TXUDF] = tx_udf;
    cause[S_TXOVF] = tx_ovf;
    cause[S_RXUDF] = rx_udf;
    cause[S_RXOVF] = rx_ovf;
    cause[S_TRAIL] = trail_fire;
    cause[S_XFER]  = xfer_evt_i;
    clr_bits       = int_clr_i ? int_clr_mask_i : '0;
    stat_nxt       = soft_rst_i ? '0 : ((int_stat_o & ~clr_bits) | cause);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_stat_o <= '0;
      irq_o      <= 1'b0;
    end else begin
      int_stat_o <= stat_nxt;
      irq_o      <= |(stat_nxt & int_en_i);
    end
  end

  always_comb begin
    fifo_stat_o                   = '0;
    fifo_stat_o[F_TXLVL +: LW]    = tx_lvl;
    fifo_stat_o[F_TXFULL]         = tx_full;
    fifo_stat_o[F_TXEMPTY]        = tx_empty;
    fifo_stat_o[F_RXLVL +: LW]    = rx_lvl;
    fifo_stat_o[F_RXFULL]         = rx_full;
    fifo_stat_o[F_RXEMPTY]        = rx_empty;
  end
endmodule

// File: rtl/dual_fifo_irq_chk.sv
module dual_fifo_irq_chk
  import dfi_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_rst_i,
  input logic             tx_en_i,
  input logic             rx_en_i,
  input logic [NSTAT-1:0] int_en_i,
  input logic             host_tx_wr_i,
  input logic             host_rx_rd_i,
  input logic [DW-1:0]    host_rx_data_o,
  input logic [31:0]      fifo_stat_o,
  input logic [NSTAT-1:0] int_stat_o,
  input logic             irq_o
);
  AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (fifo_stat_o[6:0] <= 7'(DEPTH)) && (fifo_stat_o[22:16] <= 7'(DEPTH))); // R2
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fifo_stat_o[F_TXFULL] && fifo_stat_o[F_TXEMPTY]) &&
    !(fifo_stat_o[F_RXFULL] && fifo_stat_o[F_RXEMPTY])); // R2
  AST_TX_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (host_tx_wr_i && tx_en_i && fifo_stat_o[F_TXFULL] && !soft_rst_i)
      |=> int_stat_o[S_TXOVF]); // R5
  AST_RX_UDF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_rx_rd_i && rx_en_i && fifo_stat_o[F_RXEMPTY] && !soft_rst_i)
      |=> (host_rx_data_o == '0) && int_stat_o[S_RXUDF]); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (int_en_i == '0) |=> !irq_o); // R7
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    soft_rst_i |=> (int_stat_o == '0) && !irq_o &&
                   fifo_stat_o[F_TXEMPTY] && fifo_stat_o[F_RXEMPTY]); // R9
  AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!tx_en_i && !rx_en_i) |=> fifo_stat_o[F_TXEMPTY] && fifo_stat_o[F_RXEMPTY]); // R10
endmodule

bind dual_fifo_irq dual_fifo_irq_chk #(.DEPTH(DEPTH), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .tx_en_i(tx_en_i),
  .rx_en_i(rx_en_i), .int_en_i(int_en_i), .host_tx_wr_i(host_tx_wr_i),
  .host_rx_rd_i(host_rx_rd_i), .host_rx_data_o(host_rx_data_o),
  .fifo_stat_o(fifo_stat_o), .int_stat_o(int_stat_o), .irq_o(irq_o)
);

// File: tb/dual_fifo_irq_tb_top.sv
`timescale 1ns/1ps
module dual_fifo_irq_tb_top;
  localparam int DEPTH = 64;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, soft_rst_i, tx_en_i, rx_en_i;
  logic [6:0] tx_trig_i, rx_trig_i;
  logic [9:0] int_en_i, int_clr_mask_i, int_stat_o;
  logic [3:0] trail_lim_i;
  logic host_tx_wr_i, host_rx_rd_i, eng_tx_rd_i, eng_rx_wr_i;
  logic idle_tick_i, xfer_evt_i, int_clr_i, irq_o;
  logic [7:0] host_tx_data_i, host_rx_data_o, eng_tx_data_o, eng_rx_data_i;
  logic [31:0] fifo_stat_o;

  dual_fifo_irq dut_i (.*);

  int checks = 0, errors = 0;
  logic [7:0] txq[$], rxq[$];
  logic [9:0] m_stat = '0;
  logic m_irq = 1'b0;
  logic [7:0] m_txd = '0, m_rxd = '0;
  int m_tcnt = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pack_stat();
    logic [31:0] w = '0;
    w[6:0]   = 7'(txq.size());
    w[7]     = (txq.size() == DEPTH);
    w[8]     = (txq.size() == 0);
    w[22:16] = 7'(rxq.size());
    w[23]    = (rxq.size() == DEPTH);
    w[24]    = (rxq.size() == 0);
    return w;
  endfunction

  task automatic model_edge();
    int txl = txq.size(), rxl = rxq.size();
    logic [9:0] set = '0;
    logic qual, act, clr;
    set[0] = tx_en_i && (txl <= tx_trig_i);
    set[1] = rx_en_i && (rxl >= rx_trig_i);
    set[2] = eng_tx_rd_i && tx_en_i && txl == 0;
    set[3] = host_tx_wr_i && tx_en_i && txl == DEPTH;
    set[4] = host_rx_rd_i && rx_en_i && rxl == 0;
    set[5] = eng_rx_wr_i && rx_en_i && rxl == DEPTH;
    qual = rx_en_i && rxl != 0 && rxl < rx_trig_i;
    act  = rx_en_i && (eng_rx_wr_i || host_rx_rd_i);
    clr  = soft_rst_i || !qual || act;
    set[6] = idle_tick_i && !clr && trail_lim_i != 0 && m_tcnt == trail_lim_i - 1;
    if (clr) m_tcnt = 0;
    else if (idle_tick_i && m_tcnt < trail_lim_i) m_tcnt++;
    set[9] = xfer_evt_i;
    if (soft_rst_i || !tx_en_i) begin txq.delete(); m_txd = 0; end
    else begin
      if (eng_tx_rd_i) m_txd = (txl > 0) ? txq.pop_front() : 8'h00;
      if (host_tx_wr_i && txl < DEPTH) txq.push_back(host_tx_data_i);
    end
    if (soft_rst_i || !rx_en_i) begin rxq.delete(); m_rxd = 0; end
    else begin
      if (host_rx_rd_i) m_rxd = (rxl > 0) ? rxq.pop_front() : 8'h00;
      if (eng_rx_wr_i && rxl < DEPTH) rxq.push_back(eng_rx_data_i);
    end
    m_stat = soft_rst_i ? '0 : ((m_stat & ~(int_clr_i ? int_clr_mask_i : 10'h0)) | set);
    m_irq  = soft_rst_i ? 1'b0 : |(m_stat & int_en_i);
  endtask

  task automatic clear_strobes();
    host_tx_wr_i = 0; host_rx_rd_i = 0; eng_tx_rd_i = 0; eng_rx_wr_i = 0;
    idle_tick_i = 0; xfer_evt_i = 0; int_clr_i = 0; soft_rst_i = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2 fill status word", fifo_stat_o, pack_stat());
    chk("R1 tx read data", eng_tx_data_o, m_txd);
    chk("R1 rx read data", host_rx_data_o, m_rxd);
    chk("R3 tx low-water bit", int_stat_o[0], m_stat[0]);
    chk("R4 rx high-water bit", int_stat_o[1], m_stat[1]);
    chk("R5 error bits", int_stat_o[5:2], m_stat[5:2]);
    chk("R8 trailing bit", int_stat_o[6], m_stat[6]);
    chk("R6 status word", int_stat_o, m_stat);
    chk("R7 irq", irq_o, m_irq);
    clear_strobes();
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    clear_strobes();
    rst = 1; tx_en_i = 1; rx_en_i = 1; tx_trig_i = 16; rx_trig_i = 48;
    int_en_i = '1; trail_lim_i = 15; host_tx_data_i = 0; eng_rx_data_i = 0;
    int_clr_mask_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R2 reset fill word", fifo_stat_o, 32'h0100_0100);
    chk("R6 reset status", int_stat_o, 0);
    chk("R7 reset irq", irq_o, 0);

    // R5/R1 fill transmit to full plus one, then drain past empty
    for (int i = 0; i < 65; i++) begin host_tx_wr_i = 1; host_tx_data_i = 8'(i + 3); step(); end
    chk("R5 tx overrun flagged", int_stat_o[3], 1);
    for (int i = 0; i < 65; i++) begin eng_tx_rd_i = 1; step(); end
    chk("R5 tx underrun returns zero", eng_tx_data_o, 0);
    for (int i = 0; i < 65; i++) begin eng_rx_wr_i = 1; eng_rx_data_i = 8'(200 - i); step(); end
    for (int i = 0; i < 66; i++) begin host_rx_rd_i = 1; step(); end
    chk("R5 rx underrun flagged", int_stat_o[4], 1);

    // R6 write back what was read
    int_clr_i = 1; int_clr_mask_i = int_stat_o; step();
    xfer_evt_i = 1; step();
    chk("R6 transfer event bit 9", int_stat_o[9], 1);
    int_clr_i = 1; int_clr_mask_i = 10'h200; xfer_evt_i = 1; step();
    chk("R6 same-cycle cause beats clear", int_stat_o[9], 1);

    // R8 trailing data under the trigger
    int_clr_i = 1; int_clr_mask_i = '1; step();
    for (int i = 0; i < 3; i++) begin eng_rx_wr_i = 1; eng_rx_data_i = 8'(i); step(); end
    for (int i = 0; i < 20; i++) begin idle_tick_i = 1; step(); end
    chk("R8 trailing raised", int_stat_o[6], 1);
    int_clr_i = 1; int_clr_mask_i = 10'h040; step();
    for (int i = 0; i < 20; i++) begin idle_tick_i = 1; step(); end
    chk("R8 fires once per run", int_stat_o[6], 0);

    // R7 zero enable mask
    int_en_i = '0; xfer_evt_i = 1; step(); step();
    chk("R7 masked irq low", irq_o, 0);
    int_en_i = '1;

    // R9 soft reset
    for (int i = 0; i < 5; i++) begin host_tx_wr_i = 1; eng_rx_wr_i = 1; step(); end
    soft_rst_i = 1; step();
    chk("R9 soft reset clears status", int_stat_o, 0);
    chk("R9 soft reset empties queues", fifo_stat_o, 32'h0100_0100);

    // R10 disabled queues ignore traffic
    tx_en_i = 0; rx_en_i = 0;
    host_tx_wr_i = 1; host_rx_rd_i = 1; eng_rx_wr_i = 1; eng_tx_rd_i = 1; step();
    chk("R10 disabled: no errors", int_stat_o[5:2], 0);
    chk("R10 disabled: held empty", fifo_stat_o, 32'h0100_0100);
    tx_en_i = 1; rx_en_i = 1; step();

    // random phases
    for (int seg = 0; seg < 6; seg++) begin
      int pw = (seg % 2) ? 30 : 70;
      tx_trig_i = 7'($urandom_range(0, 64));
      rx_trig_i = 7'($urandom_range(1, 64));
      int_en_i = 10'($urandom);
      trail_lim_i = 4'($urandom_range(0, 15));
      for (int c = 0; c < 600; c++) begin
        if ($urandom_range(0, 199) == 0) tx_en_i = ~tx_en_i;
        if ($urandom_range(0, 199) == 0) rx_en_i = ~rx_en_i;
        host_tx_wr_i = $urandom_range(0, 99) < pw;
        host_tx_data_i = 8'($urandom);
        eng_tx_rd_i = $urandom_range(0, 99) < 100 - pw;
        eng_rx_wr_i = $urandom_range(0, 99) < pw / 2;
        eng_rx_data_i = 8'($urandom);
        host_rx_rd_i = $urandom_range(0, 99) < (100 - pw) / 2;
        idle_tick_i = $urandom_range(0, 2) == 0;
        xfer_evt_i = $urandom_range(0, 49) == 0;
        soft_rst_i = $urandom_range(0, 299) == 0;
        int_clr_i = $urandom_range(0, 9) == 0;
        int_clr_mask_i = $urandom_range(0, 1) ? int_stat_o : 10'($urandom);
        step();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule